// File: doc/BRIEF.md
# Skip and Fill Write Address Sequencer

This block produces the write-side address stream for a transfer of 128-bit vectors into a vector memory. A one-cycle start pulse captures a vector count, a cycle length and a write length, a start byte offset and a unit select. The unit select chooses between a small and a large memory. The sequencer then offers one write step at a time. Each step carries a byte address, a strobe that says whether the step takes a vector from the input stream, a filler flag, and the step's position inside the current block. The position is what downstream masking uses to pick its per-row control.

The cycle length and the write length set the pattern. When the cycle length is at least the write length, the block runs in skip mode. It writes write-length vectors and then jumps the address over the rest of each cycle-length block. When the cycle length is below the write length, it runs in fill mode. It writes cycle-length vectors taken from the input and then adds filler writes until the block reaches write-length entries. Addresses wrap inside the selected memory. A one-cycle completion pulse follows the last write.

Top module: `skipfill_seq`

## Requirements
- R1: After reset `vld_o` and `done_o` are low.
- R2: A `start_i` pulse is taken only while idle. A pulse that arrives during a transfer leaves that transfer's step stream unchanged.
- R3: A write length of 0 counts as 256, and a vector count of 0 counts as 256 vectors.
- R4: Fill mode applies exactly when the cycle length is below the effective write length. In fill mode the consumed span is the cycle length and the block is the write length. In skip mode the consumed span is the write length and the block is the cycle length.
- R5: A step whose position is below the consumed span has `take_o`=1 and `fill_o`=0. The next step's address is 16 bytes higher.
- R6: In fill mode, a step whose position lies from the consumed span up to the block length has `take_o`=0 and `fill_o`=1. The next address is still 16 bytes higher.
- R7: In skip mode, after the step at position (consumed span − 1), the next address is 16 × (block − span + 1) bytes higher and the position restarts at 0. Otherwise the position wraps to 0 at the block length.
- R8: Unit 0 has a 4096-byte memory and unit 1 has a 16384-byte memory. The start offset is reduced to a 16-byte-aligned offset inside that memory, and every address is taken modulo the memory size.
- R9: A step is held with the same address, strobes and position until `rdy_i` is high at a clock edge. Each accepted step counts one vector toward the total.
- R10: `done_o` is high for exactly the one cycle after the final step is accepted, and `vld_o` is low in that cycle.
- R11: `pos_o` gives the step's position in its block, starting at 0 for the first step of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures the settings below |
| unit_i | input | 1 | Memory select: 0 small, 1 large |
| cl_i | input | 8 | Cycle length |
| wl_i | input | 8 | Write length (0 means 256) |
| num_i | input | 8 | Vector count (0 means 256) |
| base_i | input | 14 | Start byte offset |
| rdy_i | input | 1 | Downstream accepts the offered step |
| vld_o | output | 1 | A step is offered |
| addr_o | output | 14 | Byte address of the step |
| take_o | output | 1 | Step consumes an input vector |
| fill_o | output | 1 | Step is a filler write |
| pos_o | output | 8 | Position of the step in its block |
| done_o | output | 1 | One-cycle pulse after the last step |

## Verification
The bench builds the block with its default parameters: 8-bit length and count fields, 14-bit addresses, and memories of 4096 and 16384 bytes. With 8-bit fields, the 256 substitutions for zero write length and zero count can be reached within a short run. A full 256-vector transfer with a start near the top of the small memory sweeps the whole address ring and wraps it. The large memory is exercised with an unaligned start offset near its top edge. The zero cycle length, which gives a pure filler stream, is also in reach.

// File: rtl/skipfill_pkg.sv
package skipfill_pkg;

    parameter int CNT_W  = 8;
    parameter int ADDR_W = 14;

    typedef struct packed {
        logic              busy;
        logic              unit;
        logic              fillm;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W:0]    left;
        logic [CNT_W:0]    span;
        logic [CNT_W:0]    blk;
        logic [CNT_W:0]    pos;
    } seq_t;

endpackage

// File: rtl/skipfill_geom.sv
module skipfill_geom #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cl,
    input  logic [CNT_W-1:0] wl,
    output logic             fillm,
    output logic [CNT_W:0]   span,
    output logic [CNT_W:0]   blk
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    logic [CNT_W:0] cl_x;
    logic [CNT_W:0] wl_x;

    always_comb begin
        cl_x  = {1'b0, cl};
        wl_x  = (wl == '0) ? FULL : {1'b0, wl};
        fillm = cl_x < wl_x;
        span  = fillm ? cl_x : wl_x;
        blk   = fillm ? wl_x : cl_x;
    end
endmodule

// File: rtl/skipfill_wrap.sv
module skipfill_wrap #(
    parameter int ADDR_W      = 14,
    parameter int SMALL_BYTES = 4096,
    parameter int LARGE_BYTES = 16384
) (
    input  logic              unit,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] inc,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'(SMALL_BYTES - 16);
    localparam logic [ADDR_W-1:0] LARGE_MASK = ADDR_W'(LARGE_BYTES - 16);

    logic [ADDR_W-1:0] sum;

    always_comb begin
        sum = cur + inc;
        nxt = sum & (unit ? LARGE_MASK : SMALL_MASK);
    end
endmodule

// File: rtl/skipfill_seq.sv
module skipfill_seq
    import skipfill_pkg::*;
#(
    parameter int SMALL_BYTES = 4096,
    parameter int LARGE_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              unit_i,
    input  logic [CNT_W-1:0]  cl_i,
    input  logic [CNT_W-1:0]  wl_i,
    input  logic [CNT_W-1:0]  num_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              rdy_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              take_o,
    output logic              fill_o,
    output logic [CNT_W-1:0]  pos_o,
    output logic              done_o
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;
    localparam logic [CNT_W:0] ONE  = (CNT_W+1)'(1);

    seq_t s_d, s_q;

    logic              g_fillm;
    logic [CNT_W:0]    g_span;
    logic [CNT_W:0]    g_blk;
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] step_inc;
    logic [ADDR_W-1:0] step_nxt;
    logic [CNT_W:0]    pos_inc;
    logic [CNT_W:0]    gap;
    logic              jump;

    skipfill_geom #(.CNT_W(CNT_W)) u_geom (
        .cl(cl_i), .wl(wl_i), .fillm(g_fillm), .span(g_span), .blk(g_blk)
    );

    skipfill_wrap #(.ADDR_W(ADDR_W), .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)) u_base (
        .unit(unit_i), .cur(base_i), .inc('0), .nxt(base_w)
    );

    skipfill_wrap #(.ADDR_W(ADDR_W), .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)) u_step (
        .unit(s_q.unit), .cur(s_q.addr), .inc(step_inc), .nxt(step_nxt)
    );

    always_comb begin
        pos_inc  = s_q.pos + ONE;
        jump     = !s_q.fillm && (pos_inc != s_q.blk) && (pos_inc == s_q.span);
        gap      = jump ? (s_q.blk - s_q.span + ONE) : ONE;
        step_inc = ADDR_W'(gap) << 4;

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.unit  = unit_i;
                s_d.fillm = g_fillm;
                s_d.span  = g_span;
                s_d.blk   = g_blk;
                s_d.addr  = base_w;
                s_d.left  = (num_i == '0) ? FULL : {1'b0, num_i};
                s_d.pos   = '0;
            end
        end else if (rdy_i) begin
            s_d.addr = step_nxt;
            s_d.left = s_q.left - ONE;
            s_d.pos  = (jump || pos_inc == s_q.blk) ? '0 : pos_inc;
            if (s_q.left == ONE) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o  = s_q.busy;
    assign addr_o = s_q.addr;
    assign take_o = s_q.busy && (s_q.pos < s_q.span);
    assign fill_o = s_q.busy && !(s_q.pos < s_q.span);
    assign pos_o  = s_q.pos[CNT_W-1:0];
    assign done_o = s_q.done;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (!take_o && !fill_o)) else $error("idle step strobe"); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !rdy_i) |=> (vld_o && $stable(addr_o) && $stable(pos_o) && $stable(take_o))) else $error("step moved under stall"); // R9

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (s_q.pos < s_q.blk)) else $error("position out of block"); // R11

    AST_SKIP_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !s_q.fillm) |-> !fill_o) else $error("filler in skip mode"); // R7

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (addr_o[3:0] == 4'h0)) else $error("unaligned address"); // R8

    AST_SMALL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !s_q.unit) |-> (32'(addr_o) < SMALL_BYTES)) else $error("address beyond small memory"); // R8

    AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!vld_o && $past(vld_o && rdy_i))) else $error("done without final accept"); // R10
endmodule

// File: tb/skipfill_seq_test.sv
module skipfill_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        unit_i = 1'b0;
    logic [7:0]  cl_i = '0, wl_i = '0, num_i = '0;
    logic [13:0] base_i = '0;
    logic        rdy_i = 1'b0;
    logic        vld_o, take_o, fill_o, done_o;
    logic [13:0] addr_o;
    logic [7:0]  pos_o;

    int checks = 0;
    int errors = 0;
    int q_addr[$], q_take[$], q_fill[$], q_pos[$];
    string q_tag[$];
    bit mon_en = 0;
    bit exp_done = 0;
    bit run_over = 0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    skipfill_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .unit_i(unit_i),
        .cl_i(cl_i), .wl_i(wl_i), .num_i(num_i), .base_i(base_i),
        .rdy_i(rdy_i), .vld_o(vld_o), .addr_o(addr_o), .take_o(take_o),
        .fill_o(fill_o), .pos_o(pos_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Behavioural model of the step stream (R3 R4 R5 R6 R7 R8 R11)
    task automatic build(input int unit, input int cl, input int wl, input int num, input int base);
        int size = unit ? 16384 : 4096;
        int w = (wl == 0) ? 256 : wl;
        int n = (num == 0) ? 256 : num;
        bit fm = cl < w;
        int span = fm ? cl : w;
        int blk = fm ? w : cl;
        int a = base & (size - 16);
        int p = 0;
        while (n > 0) begin
            if (p < span || fm) begin
                q_addr.push_back(a);
                q_take.push_back(p < span);
                q_fill.push_back(!(p < span));
                q_pos.push_back(p);
                q_tag.push_back(fm ? "R6 fill-mode" : "R7 skip-mode");
                a = (a + 16) % size;
                n--;
                p++;
                if (p == blk) p = 0;
            end else begin
                a = (a + 16 * (blk - span)) % size;
                p = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            bit last;
            chk(done_o == exp_done, "R10 done pulse", done_o, exp_done);
            if (exp_done) begin
                chk(!vld_o, "R10 vld low with done", vld_o, 0);
                run_over = 1;
            end
            exp_done = 0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy_i = lfsr[0] | lfsr[2];
            if (vld_o) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R9 step beyond count", 1, 0);
                end else begin
                    chk(addr_o == q_addr[0], {q_tag[0], " R8 address"}, addr_o, q_addr[0]);
                    chk(take_o == q_take[0], {q_tag[0], " R5 take"}, take_o, q_take[0]);
                    chk(fill_o == q_fill[0], {q_tag[0], " R6 fill"}, fill_o, q_fill[0]);
                    chk(pos_o == q_pos[0], {q_tag[0], " R11 position"}, pos_o, q_pos[0]);
                    if (rdy_i) begin
                        void'(q_addr.pop_front()); void'(q_take.pop_front());
                        void'(q_fill.pop_front()); void'(q_pos.pop_front());
                        void'(q_tag.pop_front());
                        last = (q_addr.size() == 0);
                        exp_done = last;
                    end
                end
            end
        end
    end

    task automatic run(input int unit, input int cl, input int wl, input int num,
                       input int base, input bit poke);
        build(unit, cl, wl, num, base);
        run_over = 0;
        @(negedge clk);
        start_i = 1; unit_i = unit[0]; cl_i = cl[7:0]; wl_i = wl[7:0];
        num_i = num[7:0]; base_i = base[13:0];
        @(negedge clk);
        start_i = 0;
        if (poke) begin
            // R2: a start during a transfer must not disturb the stream
            repeat (2) @(negedge clk);
            start_i = 1; unit_i = ~unit_i; cl_i = 8'd9; wl_i = 8'd1;
            num_i = 8'd3; base_i = 14'h0500;
            @(negedge clk);
            start_i = 0;
        end
        for (int i = 0; i < 5000 && !run_over; i++) @(negedge clk);
        if (!run_over) chk(0, "R10 watchdog expired", 0, 1);
        chk(q_addr.size() == 0, "R9 all steps accepted", q_addr.size(), 0);
        q_addr.delete(); q_take.delete(); q_fill.delete(); q_pos.delete(); q_tag.delete();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(vld_o == 0, "R1 vld after reset", vld_o, 0);
        chk(done_o == 0, "R1 done after reset", done_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(vld_o == 0 && done_o == 0, "R1 idle after release", vld_o, 0);
        mon_en = 1;
        run(0, 4, 2, 7, 16'h0100, 0);   // R7 skip with gap
        run(1, 1, 3, 8, 16'h0020, 0);   // R6 fill
        run(0, 3, 3, 5, 16'h0040, 0);   // R4 equal lengths -> skip, no gap
        run(0, 2, 0, 10, 16'h0200, 0);  // R3 write length 0 = 256
        run(0, 1, 1, 0, 16'h0FF0, 0);   // R3 count 0 = 256, R8 full wrap
        run(1, 8, 3, 9, 16'h3FE7, 0);   // R8 unaligned start, large wrap
        run(0, 0, 4, 6, 16'h3120, 0);   // R6 pure filler, R8 start masked
        run(1, 5, 2, 11, 16'h0080, 1);  // R2 start while busy
        run(0, 2, 5, 12, 16'h0FC0, 1);  // R2 with fill and wrap
        mon_en = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule